// File: doc/BRIEF.md
# Eight-Channel Serial Sample Formatter

The formatter takes eight 24-bit conversion results and shifts them out under an externally supplied serial clock. A three-bit format code picks the output arrangement. In the time-multiplexed arrangements, a single pin carries every channel one after another. Powered-down channels either keep their slot as zeros or are squeezed out of the stream. In the discrete arrangement, each channel has its own pin. A downstream device in a daisy chain can feed its stream into the serial input, and that data follows the local channel words in the time-multiplexed stream.

The block runs on a fast system clock. The serial clock and the daisy-chain input are passed through a synchronizer, and every shift happens on a detected falling edge of the serial clock. A one-cycle frame-start strobe captures the channel words, the power-down mask and the format code. The same strobe raises either an active-low data-ready level or a one-cycle frame-sync pulse. Channel c (0-based) occupies `ch_words[24*c +: 24]`, and `dout[c]` is output pin c+1.

Top module: `chan_serial_fmt`

## Requirements
- R1: Each word is sent MSB first, with channel 0 first in the stream. After a frame load the first bit is on the pin before any serial-clock edge. Outputs change only on a frame load or a synchronized falling edge of `sclk`.
- R2: Code 001 and code 100 select fixed-slot TDM. The stream is 192 bits long, and slot k carries channel k. A slot belonging to a powered-down channel carries 24 zeros.
- R3: Code 000 and code 011 select compacted TDM. Each slot freed by a powered-down channel is filled by moving the words of the higher channels down one slot, so the stream has 24 bits for each active channel.
- R4: In every TDM code, `dout[0]` carries the stream and `dout[7:1]` stay low.
- R5: In TDM, `din` is sampled at each falling edge of `sclk`. With L local bits, the value sampled at edge m is on `dout[0]` after edge L+m-1. With L = 0, it is on `dout[0]` after edge m.
- R6: Code 010 and code 101 select discrete output. Pin c carries channel c, MSB first, and every pin is zero after the 24th falling edge.
- R7: In discrete output, the pin of a powered-down channel stays zero for the whole frame.
- R8: Codes 000, 001 and 010 drive `frame_ind` low from the frame load until the first falling edge, and high after that. Codes 011, 100 and 101 drive `frame_ind` high for exactly one clock after the load, and low after that.
- R9: A frame-start strobe reloads every shift register, even in the middle of a stream. Changes to the format code, the mask or the words after the load do not affect the frame in flight.
- R10: Codes 110 and 111 keep all `dout` pins low and hold `frame_ind` high.
- R11: After reset, every `dout` pin is low and `frame_ind` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | External serial clock (asynchronous, synchronized inside) |
| din | input | 1 | Daisy-chain serial input |
| frame_start | input | 1 | One-cycle strobe that loads a new frame |
| fmt_sel | input | 3 | Output format code, captured at load |
| pd_mask | input | 8 | Power-down mask, bit c = channel c off |
| ch_words | input | 192 | Eight 24-bit channel samples |
| dout | output | 8 | Serial data pins, bit c = pin c+1 |
| frame_ind | output | 1 | Data-ready (active low) or frame-sync pulse |

## Verification
Assertions check five properties on every cycle:
- the pins do not move without a load or a falling edge;
- the upper pins stay quiet in TDM and in the reserved codes;
- powered-down discrete pins stay at zero, and every lane is zero once 24 edges have passed;
- an empty compacted stream forwards the daisy bit;
- a load in an SPI-style code pulls the indicator low, and a load in a frame-sync code raises it.

Only the bench scenarios can show that the slot order and the compaction are correct. The same holds for the exact edge at which daisy data emerges, for the effect of a reload in the middle of a stream, and for the indifference to inputs that change after a load. The bench compares each pin after every falling edge against a stream it builds arithmetically.

// File: rtl/chsf_pkg.sv
// Shared types and helpers for the serial sample formatter.
// Assumes the format code is three bits wide; the code values are fixed by the
// surrounding system and are decoded only here.
package chsf_pkg;

    typedef enum logic [2:0] {
        FMT_SPI_DYN  = 3'b000,
        FMT_SPI_FIX  = 3'b001,
        FMT_SPI_DISC = 3'b010,
        FMT_FS_DYN   = 3'b011,
        FMT_FS_FIX   = 3'b100,
        FMT_FS_DISC  = 3'b101,
        FMT_MOD      = 3'b110,
        FMT_RSVD     = 3'b111
    } fmt_code_e;

    typedef enum logic [1:0] {
        PATH_IDLE,
        PATH_TDM_FIX,
        PATH_TDM_DYN,
        PATH_DISC
    } path_e;

    // Map a format code onto the output path it selects.
    function automatic path_e path_of(input logic [2:0] code);
        case (fmt_code_e'(code))
            FMT_SPI_DYN, FMT_FS_DYN:   return PATH_TDM_DYN;
            FMT_SPI_FIX, FMT_FS_FIX:   return PATH_TDM_FIX;
            FMT_SPI_DISC, FMT_FS_DISC: return PATH_DISC;
            default:                   return PATH_IDLE;
        endcase
    endfunction

    // True for codes that use the active-low data-ready indication.
    function automatic logic is_spi_style(input logic [2:0] code);
        return (code == FMT_SPI_DYN) || (code == FMT_SPI_FIX) || (code == FMT_SPI_DISC);
    endfunction

    // True for codes that use the one-clock frame-sync pulse.
    function automatic logic is_fsync_style(input logic [2:0] code);
        return (code == FMT_FS_DYN) || (code == FMT_FS_FIX) || (code == FMT_FS_DISC);
    endfunction

endpackage

// File: rtl/sclk_edge_sync.sv
// Brings the external serial clock and the daisy-chain input into the system
// clock domain and flags each falling edge of the serial clock.
// Assumes sclk half-periods last at least two system clocks. din travels
// through the same number of stages, so it is sampled in step with the edge.
module sclk_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_raw,
    input  logic din_raw,
    output logic fall,
    output logic din_s
);
    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] din_pipe;
    logic              sclk_last;

    // Synchronizer chains; sclk resets high so an idle-high clock gives no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '1;
            din_pipe  <= '0;
            sclk_last <= 1'b1;
        end else begin
            sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk_raw};
            din_pipe  <= {din_pipe[STAGES-2:0], din_raw};
            sclk_last <= sclk_pipe[STAGES-1];
        end
    end

    // Falling edge seen at the synchronizer output.
    always_comb fall = sclk_last & ~sclk_pipe[STAGES-1];
    // Daisy bit that lines up with the edge flag.
    always_comb din_s = din_pipe[STAGES-1];

endmodule

// File: rtl/slot_packer.sv
// Builds the local TDM stream from the channel words. Slot 0 sits at the MSB.
// In fixed mode each channel owns its slot and a powered-down slot is zero.
// In compacted mode only active channels take slots, in ascending order.
// Also reports how many local bits the stream holds.
// Assumes nothing about how many channels are active.
module slot_packer #(
    parameter int unsigned NCH = 8,
    parameter int unsigned WW  = 24,
    parameter int unsigned SW  = NCH * WW,
    parameter int unsigned LW  = $clog2(SW + 1)
) (
    input  logic [SW-1:0]  words,
    input  logic [NCH-1:0] pd,
    input  logic           compact,
    output logic [SW-1:0]  stream,
    output logic [LW-1:0]  len
);
    // Walk the channels and drop each one into the next free slot.
    always_comb begin
        int slot;
        stream = '0;
        slot   = 0;
        for (int c = 0; c < int'(NCH); c++) begin
            if (!pd[c]) begin
                stream[int'(SW) - 1 - slot * int'(WW) -: WW] = words[c*WW +: WW];
                slot = slot + 1;
            end else if (!compact) begin
                slot = slot + 1;
            end
        end
        len = compact ? LW'(slot * int'(WW)) : LW'(SW);
    end

endmodule

// File: rtl/tdm_shifter.sv
// Shift register for the single-pin stream. Its active length is set at load.
// Daisy bits enter just below the last local bit, so they follow the local
// words with no gap. With a length of zero the pin forwards each daisy bit
// as it is sampled.
// Assumes load and shift are qualified by the caller.
module tdm_shifter #(
    parameter int unsigned SW = 192,
    parameter int unsigned LW = $clog2(SW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] load_vec,
    input  logic [LW-1:0] load_len,
    input  logic          shift,
    input  logic          din,
    output logic          out
);
    logic [SW-1:0] sr;
    logic [SW-1:0] sr_nxt;
    logic [LW-1:0] len_q;
    logic          din_q;

    // Next shift value: move bits above the entry tap up by one, and insert din at the tap.
    always_comb begin
        int base;
        base      = int'(SW) - int'(len_q);
        sr_nxt[0] = (base == 0) ? din : 1'b0;
        for (int b = 1; b < int'(SW); b++) begin
            if (b > base)       sr_nxt[b] = sr[b-1];
            else if (b == base) sr_nxt[b] = din;
            else                sr_nxt[b] = 1'b0;
        end
    end

    // Stream state: reload on a frame strobe, advance on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr    <= '0;
            len_q <= '0;
            din_q <= 1'b0;
        end else if (load) begin
            sr    <= load_vec;
            len_q <= load_len;
            din_q <= 1'b0;
        end else if (shift) begin
            sr    <= sr_nxt;
            din_q <= din;
        end
    end

    // Pin value: top of the register, or the last daisy bit when the stream is empty.
    always_comb out = (len_q == '0) ? din_q : sr[SW-1];

    // R5
    din_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && len_q == '0) |=> (out == $past(din)));

endmodule

// File: rtl/lane_shifter.sv
// One shift register per channel for the discrete arrangement. Each lane
// shifts its word out MSB first and back-fills zeros, so a lane is empty
// after the word length. Lanes of powered-down channels, and every lane when
// discrete output is not selected, load zero.
// Assumes load and shift are qualified by the caller.
module lane_shifter #(
    parameter int unsigned NCH = 8,
    parameter int unsigned WW  = 24,
    parameter int unsigned CW  = $clog2(WW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              enable,
    input  logic [NCH*WW-1:0] words,
    input  logic [NCH-1:0]    pd,
    input  logic              shift,
    output logic [NCH-1:0]    lanes_out
);
    genvar g;
    generate
        for (g = 0; g < int'(NCH); g++) begin : g_lane
            logic [WW-1:0] lane;
            // Per-lane word: load the word or zero, then shift left with zero fill.
            always_ff @(posedge clk) begin
                if (!rst_n)     lane <= '0;
                else if (load)  lane <= (enable && !pd[g]) ? words[g*WW +: WW] : '0;
                else if (shift) lane <= {lane[WW-2:0], 1'b0};
            end
            always_comb lanes_out[g] = lane[WW-1];
        end
    endgenerate

    // Checker state: edges seen since the load, and the captured mask.
    logic [CW-1:0]  edge_cnt;
    logic [NCH-1:0] pd_q;

    // Saturating edge count and mask copy, used only by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            pd_q     <= '0;
        end else if (load) begin
            edge_cnt <= '0;
            pd_q     <= pd;
        end else if (shift && edge_cnt != CW'(WW)) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    // R6
    lanes_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_cnt == CW'(WW)) |-> (lanes_out == '0));

    // R7
    pd_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lanes_out & pd_q) == '0));

endmodule

// File: rtl/chan_serial_fmt.sv
// Top of the serial sample formatter. It captures the words, the mask and the
// format code on frame_start, and selects either the single-pin TDM shifter or
// the per-channel lanes. It also drives the data-ready or frame-sync indication.
// Assumes frame_start is synchronous to clk and never coincides with a falling
// edge of sclk.
module chan_serial_fmt
    import chsf_pkg::*;
#(
    parameter int unsigned NCH         = 8,
    parameter int unsigned WW          = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              frame_start,
    input  logic [2:0]        fmt_sel,
    input  logic [NCH-1:0]    pd_mask,
    input  logic [NCH*WW-1:0] ch_words,
    output logic [NCH-1:0]    dout,
    output logic              frame_ind
);
    localparam int unsigned SW = NCH * WW;
    localparam int unsigned LW = $clog2(SW + 1);

    logic          fall;
    logic          din_s;
    path_e         path_new;
    path_e         path_q;
    logic          is_tdm_q;
    logic [SW-1:0] stream;
    logic [SW-1:0] tdm_vec;
    logic [LW-1:0] stream_len;
    logic          tdm_bit;
    logic [NCH-1:0] lane_bits;
    logic          ind_q;
    logic          spi_wait_q;
    logic          fs_pulse_q;

    sclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_raw (sclk),
        .din_raw  (din),
        .fall     (fall),
        .din_s    (din_s)
    );

    // Path chosen by the code presented at the strobe.
    always_comb path_new = path_of(fmt_sel);

    slot_packer #(.NCH(NCH), .WW(WW), .SW(SW), .LW(LW)) u_pack (
        .words   (ch_words),
        .pd      (pd_mask),
        .compact (path_new == PATH_TDM_DYN),
        .stream  (stream),
        .len     (stream_len)
    );

    // Only a TDM code puts local data into the single-pin register.
    always_comb tdm_vec = (path_new == PATH_TDM_FIX || path_new == PATH_TDM_DYN) ? stream : '0;

    tdm_shifter #(.SW(SW), .LW(LW)) u_tdm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_start),
        .load_vec (tdm_vec),
        .load_len ((path_new == PATH_TDM_FIX || path_new == PATH_TDM_DYN) ? stream_len : LW'(SW)),
        .shift    (fall && is_tdm_q),
        .din      (din_s),
        .out      (tdm_bit)
    );

    lane_shifter #(.NCH(NCH), .WW(WW)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_start),
        .enable    (path_new == PATH_DISC),
        .words     (ch_words),
        .pd        (pd_mask),
        .shift     (fall && path_q == PATH_DISC),
        .lanes_out (lane_bits)
    );

    // Captured path for the frame in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)           path_q <= PATH_IDLE;
        else if (frame_start) path_q <= path_new;
    end

    always_comb is_tdm_q = (path_q == PATH_TDM_FIX) || (path_q == PATH_TDM_DYN);

    // Frame indication: SPI-style low until the first edge, or frame-sync high for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ind_q      <= 1'b1;
            spi_wait_q <= 1'b0;
            fs_pulse_q <= 1'b0;
        end else if (frame_start) begin
            ind_q      <= !is_spi_style(fmt_sel);
            spi_wait_q <= is_spi_style(fmt_sel);
            fs_pulse_q <= is_fsync_style(fmt_sel);
        end else begin
            fs_pulse_q <= 1'b0;
            if (fs_pulse_q) begin
                ind_q <= 1'b0;
            end else if (spi_wait_q && fall) begin
                ind_q      <= 1'b1;
                spi_wait_q <= 1'b0;
            end
        end
    end

    // Output pin selection by captured path.
    always_comb begin
        case (path_q)
            PATH_TDM_FIX, PATH_TDM_DYN: dout = {{(NCH-1){1'b0}}, tdm_bit};
            PATH_DISC:                  dout = lane_bits;
            default:                    dout = '0;
        endcase
    end

    always_comb frame_ind = ind_q;

    // R1
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !frame_start) |=> $stable(dout));

    // R4
    tdm_upper_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_tdm_q |-> (dout[NCH-1:1] == '0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (path_q == PATH_IDLE) |-> (dout == '0));

    // R8
    spi_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && is_spi_style(fmt_sel)) |=> !frame_ind);

    // R8
    fsync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && is_fsync_style(fmt_sel)) |=> frame_ind);

endmodule

// File: tb/chan_serial_fmt_test.sv
module chan_serial_fmt_test;
    localparam int NCH = 8;
    localparam int WW  = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sclk = 1'b1;
    logic              din = 1'b0;
    logic              frame_start = 1'b0;
    logic [2:0]        fmt_sel = 3'b000;
    logic [NCH-1:0]    pd_mask = '0;
    logic [NCH*WW-1:0] ch_words = '0;
    logic [NCH-1:0]    dout;
    logic              frame_ind;

    int checks = 0;
    int fails  = 0;

    logic [WW-1:0] word [NCH];
    int            cur_fmt;
    logic [7:0]    cur_mask;
    int            cur_fr;

    chan_serial_fmt uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din),
        .frame_start(frame_start), .fmt_sel(fmt_sel), .pd_mask(pd_mask),
        .ch_words(ch_words), .dout(dout), .frame_ind(frame_ind)
    );

    always #2 clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic din_at(input int m, input int fr);
        if (m <= 0) return 1'b0;
        return ((m * 5 + fr * 3) % 7) < 3;
    endfunction

    function automatic int path_code(input int f);
        if (f == 1 || f == 4) return 1;   // fixed TDM
        if (f == 0 || f == 3) return 2;   // compacted TDM
        if (f == 2 || f == 5) return 3;   // discrete
        return 0;
    endfunction

    function automatic int local_len(input int f, input logic [7:0] m);
        int n = 0;
        if (path_code(f) == 1) return NCH * WW;
        for (int c = 0; c < NCH; c++) if (!m[c]) n++;
        return n * WW;
    endfunction

    function automatic logic [7:0] exp_dout(input int j);
        logic [7:0] e = '0;
        int p = path_code(cur_fmt);
        if (p == 1 || p == 2) begin
            int len = local_len(cur_fmt, cur_mask);
            if (j < len) begin
                int slot = j / WW;
                int bitn = WW - 1 - (j % WW);
                int ch = slot;
                if (p == 2) begin
                    int seen = 0;
                    for (int c = 0; c < NCH; c++) begin
                        if (!cur_mask[c]) begin
                            if (seen == slot) ch = c;
                            seen++;
                        end
                    end
                end
                e[0] = cur_mask[ch] ? 1'b0 : word[ch][bitn];
            end else if (len == 0) begin
                e[0] = din_at(j, cur_fr);
            end else begin
                e[0] = din_at(j - len + 1, cur_fr);
            end
        end else if (p == 3) begin
            for (int i = 0; i < NCH; i++)
                e[i] = (j < WW && !cur_mask[i]) ? word[i][WW-1-j] : 1'b0;
        end
        return e;
    endfunction

    function automatic string tag_for(input int j);
        int p = path_code(cur_fmt);
        if (j == 0) return "R1 R9";
        if (p == 1) return (j < NCH*WW) ? "R2" : "R5";
        if (p == 2) return (j < local_len(cur_fmt, cur_mask)) ? "R3" : "R5";
        if (p == 3) return (cur_mask != 0) ? "R7" : "R6";
        return "R10";
    endfunction

    task automatic run_frame(input int f, input logic [7:0] m, input int nedges, input int fr);
        int p = path_code(f);
        cur_fmt = f; cur_mask = m; cur_fr = fr;
        for (int c = 0; c < NCH; c++) begin
            word[c] = 24'((c + 1) * 24'h1F3A5 ^ fr * 24'h9C3B1 ^ 24'h800001);
            ch_words[c*WW +: WW] = word[c];
        end
        @(negedge clk);
        fmt_sel = 3'(f); pd_mask = m; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        chk("R8", {31'b0, frame_ind}, (f <= 2) ? 32'd0 : 32'd1);
        chk(tag_for(0), {24'b0, dout}, {24'b0, exp_dout(0)});
        @(negedge clk);
        if (f >= 3 && f <= 5) chk("R8", {31'b0, frame_ind}, 32'd0);
        if (f >= 6) chk("R10", {31'b0, frame_ind}, 32'd1);
        // R9: inputs change after the load and must not disturb the frame
        fmt_sel = 3'b111; pd_mask = ~m; ch_words = ~ch_words;
        for (int j = 1; j <= nedges; j++) begin
            sclk = 1'b0; din = din_at(j, fr);
            repeat (4) @(negedge clk);
            chk(tag_for(j), {24'b0, dout}, {24'b0, exp_dout(j)});
            if (p == 1 || p == 2) chk("R4", {25'b0, dout[7:1]}, 32'd0);
            if (j == 1 && f <= 2) chk("R8", {31'b0, frame_ind}, 32'd1);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        logic [7:0] masks [6];
        int fr = 0;
        masks[0] = 8'h00; masks[1] = 8'hFF; masks[2] = 8'hA5;
        masks[3] = 8'h5A; masks[4] = 8'h80; masks[5] = 8'h7E;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        chk("R11", {24'b0, dout}, 32'd0);
        chk("R11", {31'b0, frame_ind}, 32'd1);
        for (int f = 0; f < 6; f++) begin
            for (int mi = 0; mi < 6; mi++) begin
                run_frame(f, masks[mi], (path_code(f) == 3) ? 30 : 200, fr);
                fr++;
            end
        end
        // R9: reload in the middle of a stream
        run_frame(0, 8'h12, 40, fr); fr++;
        run_frame(1, 8'h00, 200, fr); fr++;
        run_frame(5, 8'h3C, 10, fr); fr++;
        run_frame(3, 8'h81, 160, fr); fr++;
        // R10: modulator and reserved codes
        run_frame(6, 8'h00, 10, fr); fr++;
        run_frame(7, 8'h0F, 10, fr); fr++;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule